// File: doc/BRIEF.md
# ECC Write-Merge Controller

This block sits between a request port and a synchronous memory port. Every 64-bit quadword it stores gets an 8-bit SECDED check code. A memory beat is 128 bits wide and holds two quadword lanes. Each write to memory therefore carries two codes. Requests use a valid/ready handshake and carry an address, a 128-bit data beat and one enable per byte.

When every lane of a write has either all of its byte enables set or none, the block encodes the data and issues the memory write directly. When any lane is only partly enabled, the block runs a read-merge-write:

1. Read the beat.
2. Decode each lane and, in correction mode, repair single-bit errors.
3. Merge in the enabled bytes.
4. Recompute the codes.
5. Write the beat back.

Reads follow the same path. In check-only mode the raw data returns one cycle sooner, and errors are still reported. Two sticky flags record correctable and uncorrectable errors, and an address register captures where an uncorrectable error was found.

Top module: `ecc_merge_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_en`, `rsp_valid`, `err_ce` and `err_ue` are 0.
- R2: Lane q of a beat is request data bits [64q+63:64q], with byte enables [8q+7:8q]. In memory, lane q occupies bits [72q+71:72q]: the data unchanged in the low 64 bits and its code in the upper 8.
- R3: A write in which every lane is fully enabled or fully disabled issues one memory write on the edge after acceptance. `mem_qwe[q]` is set only for lanes that have enables. `req_ready` stays 1.
- R4: In correction mode, a read with a single flipped data bit returns the repaired data and sets `err_ce`. `rsp_valid` is high for one cycle, three edges after the accepting edge.
- R5: In check-only mode (`corr_mode`=0), a read returns the stored data unrepaired two edges after acceptance, and errors are still flagged.
- R6: A flipped check bit is reported as correctable and leaves the returned data unchanged.
- R7: Two flipped bits in a lane set `err_ue`, return the data unrepaired, and load `err_addr` with the request address.
- R8: A write with a partly enabled lane reads the beat, repairs single-bit errors before merging, and writes back the merged data with fresh codes.
- R9: `req_ready` is 0 from the edge that accepts a read-merge-write until its memory write has been issued.
- R10: When the merge read finds an uncorrectable error, the write still completes with fresh codes and `err_ue` is set.
- R11: `err_ce` and `err_ue` stay set until `err_clr` is asserted for a cycle, which clears them.
- R12: Lanes are judged separately. A partly enabled lane forces a read-merge-write of the beat, and a lane with no enables is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| corr_mode | input | 1 | 1 = correct, 0 = check only |
| err_clr | input | 1 | Clears the sticky error flags |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Beat address |
| req_wdata | input | 128 | Write data, two lanes |
| req_be | input | 16 | Byte enables |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 128 | Read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_qwe | output | 2 | Per-lane write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 144 | Data and codes for two lanes |
| mem_rdata | input | 144 | Read data, one cycle after a read strobe |
| err_ce | output | 1 | Sticky correctable-error flag |
| err_ue | output | 1 | Sticky uncorrectable-error flag |
| err_addr | output | AW | Address of the uncorrectable error |

## Verification
The assertions take for granted that `req_valid` is only raised while the bench is prepared to complete the transfer. They also assume the memory returns read data exactly one edge after a read strobe, and that `err_clr` is never raised in the same cycle as an error event.

The bench keeps within these assumptions:
- It drives a single request per task and lowers `req_valid` right after the accepting edge.
- It models the memory as a one-cycle synchronous array.
- It pulses `err_clr` only while the block is idle.
- It injects bit errors into stored words only between requests.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CHK, ST_RSP} mc_state_t;

   // number of Hamming check bits for a data width
   function automatic int hc_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // codeword position (1-based) of data bit j: the j-th non power of two
   function automatic int data_pos(input int j);
      int p;
      int k;
      p = 0;
      k = -1;
      while (k < j) begin
         p++;
         if ((p & (p - 1)) != 0) k++;
      end
      return p;
   endfunction

endpackage

// File: rtl/ecc_qw_enc.sv
module ecc_qw_enc #(
   parameter int DW = 64
) (
   input  logic [DW-1:0]                 data,
   output logic [ecc_pkg::hc_bits(DW):0] code
);
   localparam int HC = ecc_pkg::hc_bits(DW);

   logic [HC-1:0] chk;

   always_comb begin
      int pos;
      chk = '0;
      for (int j = 0; j < DW; j++) begin
         pos = ecc_pkg::data_pos(j);
         for (int i = 0; i < HC; i++) begin
            if (pos[i]) chk[i] = chk[i] ^ data[j];
         end
      end
   end

   assign code = {(^data) ^ (^chk), chk};

endmodule

// File: rtl/ecc_qw_dec.sv
module ecc_qw_dec #(
   parameter int DW = 64
) (
   input  logic [DW-1:0]                 data,
   input  logic [ecc_pkg::hc_bits(DW):0] code,
   output logic [DW-1:0]                 fixed,
   output logic                          ce,
   output logic                          ue
);
   localparam int HC   = ecc_pkg::hc_bits(DW);
   localparam int NPOS = DW + HC;

   logic [HC:0]   recode;
   logic [HC-1:0] syn;
   logic          ov;

   ecc_qw_enc #(.DW(DW)) u_enc (.data(data), .code(recode));

   assign syn = recode[HC-1:0] ^ code[HC-1:0];
   assign ov  = ^{data, code};

   always_comb begin
      fixed = data;
      ce    = 1'b0;
      ue    = 1'b0;
      if (ov) begin
         if (int'(syn) > NPOS) begin
            ue = 1'b1;
         end else begin
            ce = 1'b1;
            for (int j = 0; j < DW; j++) begin
               if (ecc_pkg::data_pos(j) == int'(syn)) fixed[j] = ~data[j];
            end
         end
      end else if (syn != '0) begin
         ue = 1'b1;
      end
   end

endmodule

// File: rtl/ecc_merge_ctrl.sv
module ecc_merge_ctrl #(
   parameter int AW  = 8,
   parameter int DW  = 64,
   parameter int NQW = 2,
   localparam int CW  = ecc_pkg::hc_bits(DW) + 1,
   localparam int BW  = DW * NQW,
   localparam int BEW = BW / 8,
   localparam int MW  = (DW + CW) * NQW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           corr_mode,
   input  logic           err_clr,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [BW-1:0]  req_wdata,
   input  logic [BEW-1:0] req_be,
   output logic           rsp_valid,
   output logic [BW-1:0]  rsp_rdata,
   output logic           mem_en,
   output logic           mem_we,
   output logic [NQW-1:0] mem_qwe,
   output logic [AW-1:0]  mem_addr,
   output logic [MW-1:0]  mem_wdata,
   input  logic [MW-1:0]  mem_rdata,
   output logic           err_ce,
   output logic           err_ue,
   output logic [AW-1:0]  err_addr
);
   import ecc_pkg::*;

   localparam int SW  = DW + CW;
   localparam int BPQ = DW / 8;

   if (DW % 8 != 0) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end
   if (NQW < 1) begin : g_bad_nqw
      $error("NQW must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end

   mc_state_t      st;
   logic [AW-1:0]  addr_q;
   logic [BW-1:0]  wd_q;
   logic [BEW-1:0] be_q;
   logic           mode_q;
   logic           rmw_q;
   logic [BW-1:0]  rdata_q;

   logic [NQW-1:0] lane_full, lane_any, lane_anyq, lane_ce, lane_ue;
   logic [BW-1:0]  raw_d, fix_d, mrg_d, enc_in;
   logic [MW-1:0]  enc_w;
   logic           need_rmw, in_chk;

   assign in_chk = (st == ST_CHK);

   for (genvar q = 0; q < NQW; q++) begin : g_lane
      logic [CW-1:0] enc_code;

      assign lane_full[q] = &req_be[q*BPQ +: BPQ];
      assign lane_any[q]  = |req_be[q*BPQ +: BPQ];
      assign lane_anyq[q] = |be_q[q*BPQ +: BPQ];
      assign raw_d[q*DW +: DW] = mem_rdata[q*SW +: DW];

      ecc_qw_dec #(.DW(DW)) u_dec (
         .data  (mem_rdata[q*SW +: DW]),
         .code  (mem_rdata[q*SW+DW +: CW]),
         .fixed (fix_d[q*DW +: DW]),
         .ce    (lane_ce[q]),
         .ue    (lane_ue[q])
      );

      for (genvar b = 0; b < BPQ; b++) begin : g_byte
         localparam int LO = q*DW + b*8;
         assign mrg_d[LO +: 8] = be_q[q*BPQ+b] ? wd_q[LO +: 8]
                               : (mode_q ? fix_d[LO +: 8] : raw_d[LO +: 8]);
      end

      assign enc_in[q*DW +: DW] = in_chk ? mrg_d[q*DW +: DW] : req_wdata[q*DW +: DW];

      ecc_qw_enc #(.DW(DW)) u_enc (.data(enc_in[q*DW +: DW]), .code(enc_code));

      assign enc_w[q*SW +: SW] = {enc_code, enc_in[q*DW +: DW]};
   end

   assign need_rmw  = |(lane_any & ~lane_full);
   assign req_ready = (st == ST_IDLE);
   assign rsp_valid = (in_chk && !rmw_q && !mode_q) || (st == ST_RSP);
   assign rsp_rdata = (st == ST_RSP) ? rdata_q : raw_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         addr_q    <= '0;
         wd_q      <= '0;
         be_q      <= '0;
         mode_q    <= 1'b0;
         rmw_q     <= 1'b0;
         rdata_q   <= '0;
         mem_en    <= 1'b0;
         mem_we    <= 1'b0;
         mem_qwe   <= '0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_en <= 1'b0;
         mem_we <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q   <= req_addr;
                  wd_q     <= req_wdata;
                  be_q     <= req_be;
                  mode_q   <= corr_mode;
                  rmw_q    <= req_write;
                  mem_en   <= 1'b1;
                  mem_addr <= req_addr;
                  if (req_write && !need_rmw) begin
                     mem_we    <= 1'b1;
                     mem_qwe   <= lane_any;
                     mem_wdata <= enc_w;
                  end else begin
                     mem_qwe <= '0;
                     st      <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: st <= ST_CHK;
            ST_CHK: begin
               if (rmw_q) begin
                  mem_en    <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_qwe   <= lane_anyq;
                  mem_addr  <= addr_q;
                  mem_wdata <= enc_w;
                  st        <= ST_IDLE;
               end else if (mode_q) begin
                  rdata_q <= fix_d;
                  st      <= ST_RSP;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_RSP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // sticky error status; a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_ce   <= 1'b0;
         err_ue   <= 1'b0;
         err_addr <= '0;
      end else begin
         if (err_clr) begin
            err_ce <= 1'b0;
            err_ue <= 1'b0;
         end
         if (in_chk && |lane_ce) err_ce <= 1'b1;
         if (in_chk && |lane_ue) begin
            err_ue   <= 1'b1;
            err_addr <= addr_q;
         end
      end
   end

endmodule

// File: rtl/ecc_merge_chk.sv
module ecc_merge_chk #(
   parameter int NQW = 2,
   parameter int BEW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_ready,
   input logic           req_write,
   input logic [BEW-1:0] req_be,
   input logic           mem_en,
   input logic           mem_we,
   input logic           rsp_valid,
   input logic           err_clr,
   input logic           err_ce,
   input logic           err_ue
);
   localparam int BPQ = BEW / NQW;

   logic [NQW-1:0] part;
   logic           acc, any_part;

   for (genvar q = 0; q < NQW; q++) begin : g_p
      logic [BPQ-1:0] e;
      assign e       = req_be[q*BPQ +: BPQ];
      assign part[q] = (e != '0) && (e != '1);
   end

   assign any_part = |part;
   assign acc      = req_valid && req_ready;

   // R3
   full_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write && !any_part |=> mem_en && mem_we);

   // R8
   rmw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (!req_write || any_part) |=> mem_en && !mem_we);

   // R9
   rmw_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write && any_part |=> !req_ready);

   // R4
   rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R11
   ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_ue && !err_clr |=> err_ue);

   // R11
   ce_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_ce && !err_clr |=> err_ce);

endmodule

bind ecc_merge_ctrl ecc_merge_chk #(.NQW(NQW), .BEW(BEW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_write (req_write),
   .req_be    (req_be),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .rsp_valid (rsp_valid),
   .err_clr   (err_clr),
   .err_ce    (err_ce),
   .err_ue    (err_ue)
);

// File: tb/tb_ecc_merge_ctrl.sv
module tb_ecc_merge_ctrl;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          corr_mode = 1'b1;
   logic          err_clr = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [127:0]  req_wdata = '0;
   logic [15:0]   req_be = '0;
   logic          rsp_valid;
   logic [127:0]  rsp_rdata;
   logic          mem_en, mem_we;
   logic [1:0]    mem_qwe;
   logic [AW-1:0] mem_addr;
   logic [143:0]  mem_wdata;
   logic [143:0]  mem_rdata = '0;
   logic          err_ce, err_ue;
   logic [AW-1:0] err_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [143:0]  mem [0:255];
   logic          inj_go = 1'b0;
   logic [AW-1:0] inj_addr = '0;
   logic [143:0]  inj_mask = '0;

   localparam logic [63:0] D0 = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] D1 = 64'hFEDC_BA98_7654_3210;

   always #10 clk = ~clk;

   ecc_merge_ctrl #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .corr_mode(corr_mode), .err_clr(err_clr),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_qwe(mem_qwe), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .err_ce(err_ce), .err_ue(err_ue), .err_addr(err_addr)
   );

   // one-cycle synchronous memory model with error injection
   initial for (int i = 0; i < 256; i++) mem[i] = '0;
   always @(posedge clk) begin
      if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (mem_en) begin
         if (mem_we) begin
            if (mem_qwe[0]) mem[mem_addr][71:0]   <= mem_wdata[71:0];
            if (mem_qwe[1]) mem[mem_addr][143:72] <= mem_wdata[143:72];
         end else begin
            mem_rdata <= mem[mem_addr];
         end
      end
   end

   task automatic check(input string req, input logic [143:0] act, input logic [143:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // drives one request; returns the ready value seen one cycle after acceptance
   task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [127:0] d,
                        input logic [15:0] be, output bit rdy_after);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      rdy_after = req_ready;
   endtask

   task automatic wait_idle();
      while (!req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [127:0] d, input logic [15:0] be);
      bit r;
      issue(1'b1, a, d, be, r);
      wait_idle();
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [127:0] d, output int lat);
      bit r;
      issue(1'b0, a, '0, '0, r);
      lat = 1;
      while (!rsp_valid && lat < 10) begin
         @(negedge clk);
         lat++;
      end
      d = rsp_rdata;
      wait_idle();
   endtask

   task automatic inject(input logic [AW-1:0] a, input logic [143:0] m);
      @(negedge clk);
      inj_addr = a; inj_mask = m; inj_go = 1'b1;
      @(negedge clk);
      inj_go = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ready", req_ready, 1);
      check("R1 mem_en", mem_en, 0);
      check("R1 rsp_valid", rsp_valid, 0);
      check("R1 flags", {err_ce, err_ue}, 0);
   endtask

   task automatic t_full_write();
      logic [127:0] d; int lat; bit r;
      issue(1'b1, 8'd3, {D1, D0}, 16'hFFFF, r);
      check("R3 ready stays high", r, 1);
      wait_idle();
      check("R2 lane0 data field", mem[3][63:0], D0);
      check("R2 lane1 data field", mem[3][135:72], D1);
      rd(8'd3, d, lat);
      check("R3 readback", d, {D1, D0});
      check("R4 clean read latency", lat, 3);
      check("R4 no flags on clean read", {err_ce, err_ue}, 0);
   endtask

   task automatic t_single_fix();
      logic [127:0] d; int lat;
      wr(8'd4, {D1, D0}, 16'hFFFF);
      inject(8'd4, 144'd1 << 17);
      rd(8'd4, d, lat);
      check("R4 corrected data", d, {D1, D0});
      check("R4 latency", lat, 3);
      check("R4 ce set", {err_ce, err_ue}, 2'b10);
      repeat (3) @(negedge clk);
      check("R11 ce sticky", err_ce, 1);
      clear_flags();
      check("R11 cleared", {err_ce, err_ue}, 0);
   endtask

   task automatic t_check_only();
      logic [127:0] d; int lat;
      wr(8'd10, {D1, D0}, 16'hFFFF);
      inject(8'd10, 144'd1 << (72 + 10));
      corr_mode = 1'b0;
      rd(8'd10, d, lat);
      corr_mode = 1'b1;
      check("R5 raw data returned", d, {D1 ^ (64'd1 << 10), D0});
      check("R5 latency", lat, 2);
      check("R5 ce flagged", {err_ce, err_ue}, 2'b10);
      clear_flags();
   endtask

   task automatic t_code_bit();
      logic [127:0] d; int lat;
      wr(8'd11, {D1, D0}, 16'hFFFF);
      inject(8'd11, 144'd1 << 66);
      rd(8'd11, d, lat);
      check("R6 data unchanged", d, {D1, D0});
      check("R6 correctable", {err_ce, err_ue}, 2'b10);
      clear_flags();
   endtask

   task automatic t_double();
      logic [127:0] d; int lat;
      wr(8'd9, {D1, D0}, 16'hFFFF);
      inject(8'd9, 144'd3 << 72);
      rd(8'd9, d, lat);
      check("R7 data unrepaired", d, {D1 ^ 64'd3, D0});
      check("R7 ue set", err_ue, 1);
      check("R7 err_addr", err_addr, 9);
      clear_flags();
   endtask

   task automatic t_rmw_fix();
      logic [127:0] d; int lat; bit r;
      wr(8'd5, {D1, D0}, 16'hFFFF);
      inject(8'd5, 144'd1 << 40);
      issue(1'b1, 8'd5, {64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 32'hAABB_CCDD}, 16'h000F, r);
      check("R9 ready low during merge", r, 0);
      wait_idle();
      check("R8 ce during merge", err_ce, 1);
      clear_flags();
      rd(8'd5, d, lat);
      check("R8 merged and repaired", d, {D1, D0[63:32], 32'hAABB_CCDD});
      check("R8 fresh codes", {err_ce, err_ue}, 0);
   endtask

   task automatic t_rmw_ue();
      logic [127:0] d; int lat;
      wr(8'd6, {D1, D0}, 16'hFFFF);
      inject(8'd6, 144'd3 << 40);
      wr(8'd6, {64'h0, 32'h0, 32'h1122_3344}, 16'h000F);
      check("R10 ue flagged", err_ue, 1);
      check("R10 err_addr", err_addr, 6);
      clear_flags();
      rd(8'd6, d, lat);
      check("R10 write completed", d, {D1, D0[63:32] ^ 32'h300, 32'h1122_3344});
      check("R10 fresh codes", {err_ce, err_ue}, 0);
   endtask

   task automatic t_lanes();
      logic [127:0] d; int lat; bit r;
      wr(8'd7, {D1, D0}, 16'hFFFF);
      issue(1'b1, 8'd7, {64'hAAAA_5555_AAAA_5555, 64'h1234}, 16'hFF00, r);
      check("R12 whole lane direct", r, 1);
      wait_idle();
      rd(8'd7, d, lat);
      check("R12 untouched lane kept", d, {64'hAAAA_5555_AAAA_5555, D0});
      issue(1'b1, 8'd7, {64'h0, 64'h0F0F_0F0F_0F0F_0F0F}, 16'h0FFF, r);
      check("R12 partial lane merges", r, 0);
      wait_idle();
      rd(8'd7, d, lat);
      check("R12 mixed beat", d, {32'hAAAA_5555, 32'h0, 64'h0F0F_0F0F_0F0F_0F0F});
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_write();
      t_single_fix();
      t_check_only();
      t_code_bit();
      t_double();
      t_rmw_fix();
      t_rmw_ue();
      t_lanes();
      finish_run();
   end

endmodule